// File: doc/BRIEF.md
# Immediate-Operand Integer Execute Unit

This unit executes the register-immediate arithmetic and logic operations of a 32-bit integer pipeline. Each issued instruction supplies a 6-bit operation code, the value of the source register and a 16-bit immediate. One clock later the unit presents a registered result, a write-enable for the destination register and an overflow fault flag, all qualified by an output valid strobe.

Each operation widens the immediate in its own way. Sign extension feeds the additions and both compares. Zero extension feeds the bitwise operations. The upper-load operation places the immediate in the top half of the word. Only the trapping add can raise a fault, and a fault cancels that instruction's register write. Codes the unit does not recognise leave both write-enable and fault low.

Top module: `imm_alu_top`

## Requirements
- R1: While reset is held, and in the first cycle after its release, out_valid, out_wr_en and out_fault are 0.
- R2: An instruction issued with in_valid=1 in cycle N gives out_valid=1 in cycle N+1. A cycle with in_valid=0 gives out_valid=0, out_wr_en=0 and out_fault=0 in the next cycle.
- R3: Code 0x08 (trapping add) produces src + sign-extended immediate. When the signed 32-bit addition overflows, out_fault=1 and out_wr_en=0. Otherwise out_fault=0 and out_wr_en=1.
- R4: Code 0x09 (non-trapping add) produces the same sum, with out_fault=0 and out_wr_en=1 in every case, overflow included.
- R5: Code 0x0A produces 1 when src is less than the sign-extended immediate in a signed compare, and 0 otherwise. Code 0x0B makes the same comparison with both values taken as unsigned 32-bit numbers.
- R6: Codes 0x0C, 0x0D and 0x0E produce src AND, OR and XOR (respectively) the zero-extended immediate.
- R7: Code 0x0F produces the immediate in bits 31:16, with bits 15:0 equal to 0, and ignores src.
- R8: Any other code gives out_wr_en=0 and out_fault=0 while out_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_op | input | 6 | Operation code |
| in_src | input | 32 | Source register value |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Value for the destination register |
| out_wr_en | output | 1 | Destination write permitted |
| out_fault | output | 1 | Signed overflow on trapping add |

## Verification
The hardest conditions to reach are the two signed-overflow boundaries of the trapping add, and the cases where the unsigned compare disagrees with the signed one because a negative immediate becomes a huge unsigned value. Stimulus reaches both with a source operand grid built around 0, ±1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, crossed with immediates 0, 1, 0x7FFF, 0x8000 and 0xFFFF. This grid lands exactly on the wrap points and also crosses the sign boundary of the compares. Every code from 0 to 63 is swept over that grid.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  localparam int XLEN = 32;
  localparam int ILEN = 16;
  localparam int OPW  = 6;

  typedef enum logic [OPW-1:0] {
    OP_ADDT = 6'h08,
    OP_ADDN = 6'h09,
    OP_LTS  = 6'h0A,
    OP_LTU  = 6'h0B,
    OP_AND  = 6'h0C,
    OP_OR   = 6'h0D,
    OP_XOR  = 6'h0E,
    OP_UPR  = 6'h0F
  } imm_op_e;

  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_HIGH} ext_e;

  typedef struct packed {
    logic            known;
    logic            trap_on_ovf;
    ext_e            ext;
    logic [2:0]      fn;
  } dec_t;

  localparam logic [2:0] FN_ADD = 3'd0;
  localparam logic [2:0] FN_LTS = 3'd1;
  localparam logic [2:0] FN_LTU = 3'd2;
  localparam logic [2:0] FN_AND = 3'd3;
  localparam logic [2:0] FN_OR  = 3'd4;
  localparam logic [2:0] FN_XOR = 3'd5;
  localparam logic [2:0] FN_PASS = 3'd6;

  function automatic logic add_overflows(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [XLEN-1:0] s;
    s = a + b;
    return (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic signed_less(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction
endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
  import imm_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  output dec_t           dec
);
  always_comb begin
    dec = '{known: 1'b1, trap_on_ovf: 1'b0, ext: EXT_SIGN, fn: FN_ADD};
    case (op)
      OP_ADDT: dec.trap_on_ovf = 1'b1;
      OP_ADDN: ;
      OP_LTS:  dec.fn = FN_LTS;
      OP_LTU:  dec.fn = FN_LTU;
      OP_AND:  begin dec.fn = FN_AND; dec.ext = EXT_ZERO; end
      OP_OR:   begin dec.fn = FN_OR;  dec.ext = EXT_ZERO; end
      OP_XOR:  begin dec.fn = FN_XOR; dec.ext = EXT_ZERO; end
      OP_UPR:  begin dec.fn = FN_PASS; dec.ext = EXT_HIGH; end
      default: dec.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/imm_alu_extend.sv
module imm_alu_extend
  import imm_alu_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = ILEN
) (
  input  logic [IW-1:0] imm,
  input  ext_e          mode,
  output logic [W-1:0]  opnd
);
  localparam int PAD = W - IW;
  always_comb begin
    case (mode)
      EXT_ZERO: opnd = {{PAD{1'b0}}, imm};
      EXT_HIGH: opnd = {imm, {PAD{1'b0}}};
      default:  opnd = {{PAD{imm[IW-1]}}, imm};
    endcase
  end

  always_comb begin
    if (mode == EXT_HIGH) assert_high_low_zero_R7: assert (opnd[PAD-1:0] == '0);
  end
endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
  import imm_alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn,
  output logic [W-1:0] y,
  output logic         ovf
);
  logic [W-1:0] sum;
  assign sum = a + b;
  assign ovf = (fn == FN_ADD) && add_overflows(a, b);

  always_comb begin
    case (fn)
      FN_ADD:  y = sum;
      FN_LTS:  y = {{(W-1){1'b0}}, signed_less(a, b)};
      FN_LTU:  y = {{(W-1){1'b0}}, (a < b)};
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      default: y = b;
    endcase
  end

  always_comb begin
    if (fn == FN_LTS || fn == FN_LTU) assert_cmp_bool_R5: assert (y[W-1:1] == '0);
  end
endmodule

// File: rtl/imm_alu_top.sv
module imm_alu_top
  import imm_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPW-1:0]    in_op,
  input  logic [XLEN-1:0]   in_src,
  input  logic [ILEN-1:0]   in_imm,
  output logic              out_valid,
  output logic [XLEN-1:0]   out_result,
  output logic              out_wr_en,
  output logic              out_fault
);
  dec_t            dec;
  logic [XLEN-1:0] ext_opnd;
  logic [XLEN-1:0] alu_y;
  logic            alu_ovf;
  logic            fault_evt;
  logic            write_evt;

  imm_alu_decode u_dec (.op(in_op), .dec(dec));
  imm_alu_extend #(.W(XLEN), .IW(ILEN)) u_ext (.imm(in_imm), .mode(dec.ext), .opnd(ext_opnd));
  imm_alu_core   #(.W(XLEN)) u_core (.a(in_src), .b(ext_opnd), .fn(dec.fn), .y(alu_y), .ovf(alu_ovf));

  assign fault_evt = in_valid && dec.known && dec.trap_on_ovf && alu_ovf;
  assign write_evt = in_valid && dec.known && !fault_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_fault  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid  <= in_valid;
      out_wr_en  <= write_evt;
      out_fault  <= fault_evt;
      out_result <= alu_y;
    end
  end

  assert_fault_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> !out_wr_en);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_wr_en && !out_fault));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_ADDN) |=> (out_wr_en && !out_fault));
  assert_unknown_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op < 6'h08 || in_op > 6'h0F)) |=> (!out_wr_en && !out_fault));
endmodule

// File: tb/tb_imm_alu_top.sv
module tb_imm_alu_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [5:0] in_op = 0;
  logic [31:0] in_src = 0;
  logic [15:0] in_imm = 0;
  logic out_valid, out_wr_en, out_fault;
  logic [31:0] out_result;
  int checks = 0, errors = 0;
  bit done = 0;

  imm_alu_top dut (.clk, .rst_n, .in_valid, .in_op, .in_src, .in_imm,
                   .out_valid, .out_result, .out_wr_en, .out_fault);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [5:0] op, logic [31:0] s, logic [15:0] im);
    logic [31:0] sx, zx, r;
    logic we, fl;
    longint sum;
    string req;
    sx = {{16{im[15]}}, im};
    zx = {16'h0, im};
    r = 0; we = 1; fl = 0; req = "R8";
    sum = longint'($signed(s)) + longint'($signed(sx));
    case (op)
      6'h08: begin req = "R3"; r = s + sx;
               if (sum > 64'sd2147483647 || sum < -64'sd2147483648) begin fl = 1; we = 0; end end
      6'h09: begin req = "R4"; r = s + sx; end
      6'h0A: begin req = "R5"; r = (longint'($signed(s)) < longint'($signed(sx))) ? 1 : 0; end
      6'h0B: begin req = "R5"; r = ({32'h0, s} < {32'h0, sx}) ? 1 : 0; end
      6'h0C: begin req = "R6"; r = s & zx; end
      6'h0D: begin req = "R6"; r = s | zx; end
      6'h0E: begin req = "R6"; r = s ^ zx; end
      6'h0F: begin req = "R7"; r = im * 32'h10000; end
      default: we = 0;
    endcase
    @(negedge clk);
    in_valid = 1; in_op = op; in_src = s; in_imm = im;
    @(negedge clk);
    in_valid = 0;
    if (op >= 6'h08 && op <= 6'h0F)
      chk(req, {out_valid, out_wr_en, out_fault, out_result}, {1'b1, we, fl, r});
    else
      chk(req, {out_valid, out_wr_en, out_fault, 32'h0}, {1'b1, 1'b0, 1'b0, 32'h0});
  endtask

  initial begin
    logic [31:0] srcs [8];
    logic [15:0] imms [6];
    srcs = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h7FFF8000, 32'h80007FFF, 32'h12345678};
    imms = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
    repeat (3) @(negedge clk);
    chk("R1", {out_valid, out_wr_en, out_fault}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {out_valid, out_wr_en, out_fault}, 3'b000);
    for (int o = 0; o < 64; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 6; j++)
          run(o[5:0], srcs[i], imms[j]);
    run(6'h08, 32'h7FFFFFFF, 16'h0001);
    run(6'h08, 32'h80000000, 16'hFFFF);
    run(6'h0B, 32'h00000005, 16'hFFFF);
    run(6'h0F, 32'hDEADBEEF, 16'hBEEF);
    @(negedge clk);
    chk("R2", {out_valid, out_wr_en, out_fault}, 3'b000);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule